// File: doc/BRIEF.md
# Nine-Bit Multiprocessor UART

This block is a full-duplex asynchronous serial port. Every frame is eleven bit times long and carries one data byte and a ninth bit under software control. Software can use the ninth bit as a parity value or as an address marker on a shared multi-drop bus. The host drives the block through a small write port with three addresses: transmit data, control, and flag clear. The receive byte, the received ninth bit, the two event flags and the transmitter busy state are visible at all times on dedicated outputs. An external rate generator supplies a single-cycle enable, `baudTick`, at sixteen times the bit rate. Both the transmitter and the receiver advance only on that tick.

The receiver can run in an address-filter mode. In that mode, frames whose ninth bit is 0 are discarded, so a node hears only address frames until software turns the filter off. The receiver also discards any frame that completes while the previous receive flag is still pending. This protects unread data from being overwritten. One interrupt output combines both event flags behind an enable bit.

Top module: `uart9_mp`

## Requirements
- R1: `txLine` is high while the transmitter is idle. A frame is driven as a low start bit, then data bits 0 through 7 in that order, then the ninth bit, then a high stop bit. Each bit lasts 16 `baudTick` pulses.
- R2: The ninth transmitted bit equals control bit 2 (`txNinth`) as it stood when the frame was started.
- R3: A write to address 0 while `txBusy` is low starts a frame with `hostWrData` and sets `txBusy` on the next cycle. A write to address 0 while `txBusy` is high is ignored and the frame in progress continues unchanged.
- R4: `txDoneFlag` rises on the tick at which the stop bit begins. It stays set until the host writes address 2 with bit 0 set.
- R5: The receiver starts a frame only if control bit 0 (`rxEnable`) is 1 when the falling start edge is seen. Frames arriving with it at 0 change nothing.
- R6: Each received bit is the majority of three samples taken on ticks 7, 8 and 9 of that bit. A start bit that votes high is treated as a glitch, and the receiver goes back to waiting for a new falling edge.
- R7: The stop bit level is not checked. A frame with a low stop bit is accepted under the same conditions as any other frame.
- R8: If `rxFlag` is already set when a frame completes, the frame is discarded and `rxData` and `rxNinth` stay unchanged.
- R9: When control bit 1 (`mpMode`) is 1, a frame whose ninth bit is 0 is discarded. When it is 0, the ninth bit has no effect on acceptance.
- R10: An accepted frame loads its byte into `rxData` and its ninth bit into `rxNinth`, and sets `rxFlag`. `rxFlag` stays set until the host writes address 2 with bit 1 set.
- R11: `irq` is high exactly when control bit 3 (`intEnable`) is 1 and at least one of `txDoneFlag` and `rxFlag` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baudTick | input | 1 | One-cycle enable at 16x the bit rate |
| hostWr | input | 1 | Host write strobe |
| hostAddr | input | 2 | 0 = transmit data, 1 = control, 2 = flag clear |
| hostWrData | input | 8 | Host write data |
| rxLine | input | 1 | Serial receive line |
| txLine | output | 1 | Serial transmit line |
| txBusy | output | 1 | A frame is being transmitted |
| txDoneFlag | output | 1 | Transmit-complete flag |
| rxFlag | output | 1 | Receive flag |
| rxData | output | 8 | Last accepted data byte |
| rxNinth | output | 1 | Ninth bit of the last accepted frame |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest cases to reach are the receive paths that must leave no trace. These are a frame refused because the flag is still pending, a frame refused by the address filter, and a start pulse too short to survive the mid-bit vote. The bench drives its own serial frames aligned to the tick it generates, so it controls the ninth bit, the stop level and the length of the start pulse. Each refused or glitched event is followed at once by a check that `rxData`, `rxNinth` and `rxFlag` keep their earlier values. A clean frame is then sent to prove the receiver returned to idle. One run also transmits and receives at the same time to cover full-duplex operation.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  localparam int FRAME_BITS = 11;
  localparam int DATA_W     = 8;

  localparam logic [1:0] ADDR_DATA  = 2'd0;
  localparam logic [1:0] ADDR_CTRL  = 2'd1;
  localparam logic [1:0] ADDR_CLEAR = 2'd2;

  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic txStopEnter;
    logic rxVote;
    logic rxShiftIn;
    logic rxFrameEnd;
  } strobes_t;
endpackage

// File: rtl/uart9_ctrl.sv
module uart9_ctrl
  import uart9_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     baudTick,
  input  logic     txStart,
  input  logic     rxEnable,
  input  logic     rxLineS,
  input  logic     voteBit,
  output strobes_t strb,
  output logic     txBusy
);
  localparam int TW = $clog2(OVS);
  localparam logic [TW-1:0] LAST = TW'(OVS - 1);
  localparam logic [TW-1:0] V0   = TW'(OVS / 2 - 1);
  localparam logic [TW-1:0] V1   = TW'(OVS / 2);
  localparam logic [TW-1:0] DEC  = TW'(OVS / 2 + 1);
  localparam logic [3:0] STOP_IDX  = 4'(FRAME_BITS - 1);
  localparam logic [3:0] NINTH_IDX = 4'(FRAME_BITS - 2);

  logic [TW-1:0] txTick, rxTick;
  logic [3:0]    txBit, rxBit;
  logic          rxActive;
  logic          txWrap, rxStep, rxDecide, rxStart;

  assign txWrap   = txBusy && baudTick && (txTick == LAST);
  assign rxStep   = rxActive && baudTick;
  assign rxDecide = rxStep && (rxTick == DEC);
  assign rxStart  = !rxActive && baudTick && rxEnable && !rxLineS;

  always_comb begin
    strb             = '0;
    strb.txLoad      = txStart && !txBusy;
    strb.txShift     = txWrap && (txBit != STOP_IDX);
    strb.txStopEnter = txWrap && (txBit == NINTH_IDX);
    strb.rxVote      = rxStep && ((rxTick == V0) || (rxTick == V1));
    strb.rxShiftIn   = rxDecide && (rxBit != 4'd0) && (rxBit != STOP_IDX);
    strb.rxFrameEnd  = rxDecide && (rxBit == STOP_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txTick <= '0;
      txBit  <= '0;
    end else if (strb.txLoad) begin
      txBusy <= 1'b1;
      txTick <= '0;
      txBit  <= '0;
    end else if (txBusy && baudTick) begin
      txTick <= (txTick == LAST) ? '0 : txTick + 1'b1;
      if (txTick == LAST) begin
        if (txBit == STOP_IDX) txBusy <= 1'b0;
        else                   txBit  <= txBit + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxActive <= 1'b0;
      rxTick   <= '0;
      rxBit    <= '0;
    end else if (rxStart) begin
      rxActive <= 1'b1;
      rxTick   <= TW'(1);
      rxBit    <= '0;
    end else if (rxStep) begin
      if (rxDecide && (((rxBit == 4'd0) && voteBit) || (rxBit == STOP_IDX))) begin
        rxActive <= 1'b0;
      end else begin
        rxTick <= (rxTick == LAST) ? '0 : rxTick + 1'b1;
        if (rxTick == LAST) rxBit <= rxBit + 4'd1;
      end
    end
  end

  // R5
  rx_start_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxActive) |-> ($past(rxEnable) && !$past(rxLineS)));

  // R3
  tx_idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!txBusy && !txStart) |=> !txBusy);
endmodule

// File: rtl/uart9_dp.sv
module uart9_dp
  import uart9_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic [1:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              rxLine,
  input  strobes_t          strb,
  output logic              rxLineS,
  output logic              voteBit,
  output logic              rxEnable,
  output logic              txLine,
  output logic              txDoneFlag,
  output logic              rxFlag,
  output logic [DATA_W-1:0] rxData,
  output logic              rxNinth,
  output logic              irq
);
  logic              mpMode, txNinth, intEnable;
  logic              syncA;
  logic [1:0]        votes;
  logic [DATA_W:0]   rxSh;
  logic [FRAME_BITS-1:0] txSh;
  logic              accept, wrClear;

  assign voteBit = (votes[0] & votes[1]) | (votes[0] & rxLineS) | (votes[1] & rxLineS);
  assign accept  = strb.rxFrameEnd && !rxFlag && (!mpMode || rxSh[DATA_W]);
  assign wrClear = hostWr && (hostAddr == ADDR_CLEAR);
  assign txLine  = txSh[0];
  assign irq     = intEnable && (txDoneFlag || rxFlag);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {rxEnable, mpMode, txNinth, intEnable} <= '0;
    end else if (hostWr && (hostAddr == ADDR_CTRL)) begin
      rxEnable  <= hostWrData[0];
      mpMode    <= hostWrData[1];
      txNinth   <= hostWrData[2];
      intEnable <= hostWrData[3];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh <= '1;
    end else if (strb.txLoad) begin
      txSh <= {1'b1, txNinth, hostWrData, 1'b0};
    end else if (strb.txShift) begin
      txSh <= {1'b1, txSh[FRAME_BITS-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= 1'b1;
      rxLineS <= 1'b1;
      votes   <= '1;
      rxSh    <= '0;
    end else begin
      syncA   <= rxLine;
      rxLineS <= syncA;
      if (strb.rxVote)    votes <= {votes[0], rxLineS};
      if (strb.rxShiftIn) rxSh  <= {voteBit, rxSh[DATA_W:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txDoneFlag <= 1'b0;
      rxFlag     <= 1'b0;
      rxData     <= '0;
      rxNinth    <= 1'b0;
    end else begin
      if (strb.txStopEnter)             txDoneFlag <= 1'b1;
      else if (wrClear && hostWrData[0]) txDoneFlag <= 1'b0;
      if (accept) begin
        rxFlag  <= 1'b1;
        rxData  <= rxSh[DATA_W-1:0];
        rxNinth <= rxSh[DATA_W];
      end else if (wrClear && hostWrData[1]) begin
        rxFlag <= 1'b0;
      end
    end
  end

  // R8
  rx_pending_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rxFlag) && rxFlag) |-> ($stable(rxData) && $stable(rxNinth)));

  // R9
  rx_filter_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxFlag) && $past(mpMode)) |-> rxNinth);
endmodule

// File: rtl/uart9_mp.sv
module uart9_mp
  import uart9_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              hostWr,
  input  logic [1:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              rxLine,
  output logic              txLine,
  output logic              txBusy,
  output logic              txDoneFlag,
  output logic              rxFlag,
  output logic [DATA_W-1:0] rxData,
  output logic              rxNinth,
  output logic              irq
);
  strobes_t strb;
  logic rxLineS, voteBit, rxEnable, txStart;

  assign txStart = hostWr && (hostAddr == ADDR_DATA);

  uart9_ctrl #(.OVS(OVS)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .txStart(txStart),
    .rxEnable(rxEnable), .rxLineS(rxLineS), .voteBit(voteBit),
    .strb(strb), .txBusy(txBusy)
  );

  uart9_dp u_dp (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .rxLine(rxLine), .strb(strb),
    .rxLineS(rxLineS), .voteBit(voteBit), .rxEnable(rxEnable),
    .txLine(txLine), .txDoneFlag(txDoneFlag), .rxFlag(rxFlag),
    .rxData(rxData), .rxNinth(rxNinth), .irq(irq)
  );

  // R4
  tx_done_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txDoneFlag) |-> txBusy);

  // R1
  tx_start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> !txLine);
endmodule

// File: tb/uart9_mp_tb.sv
module uart9_mp_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baudTick = 1'b0;
  logic hostWr = 1'b0;
  logic [1:0] hostAddr = 2'd0;
  logic [7:0] hostWrData = 8'd0;
  logic rxLine = 1'b1;
  logic txLine, txBusy, txDoneFlag, rxFlag, rxNinth, irq;
  logic [7:0] rxData;

  int checks = 0;
  int fails = 0;
  int tickDiv = 0;

  // behavioural reference state
  logic        mBusy = 1'b0;
  int          mTicks = 0;
  logic [10:0] mFrame = '1;
  logic        mTxDone = 1'b0, mRxFlag = 1'b0, mRxNinth = 1'b0;
  logic [7:0]  mRxData = 8'd0;
  logic [3:0]  mCtrl = 4'd0;
  logic        rxWindow = 1'b0;

  always #4 clk = ~clk;

  uart9_mp u_dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .rxLine(rxLine),
    .txLine(txLine), .txBusy(txBusy), .txDoneFlag(txDoneFlag),
    .rxFlag(rxFlag), .rxData(rxData), .rxNinth(rxNinth), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    baudTick <= (tickDiv == 3);
    tickDiv  <= (tickDiv == 3) ? 0 : tickDiv + 1;
  end

  always @(posedge clk) begin
    logic setNow;
    setNow = 1'b0;
    if (!rstN) begin
      mBusy = 0; mTicks = 0; mTxDone = 0; mRxFlag = 0; mCtrl = 0;
    end else begin
      if (hostWr && hostAddr == 2'd0 && !mBusy) begin
        mBusy = 1; mTicks = 0;
        mFrame = {1'b1, mCtrl[2], hostWrData, 1'b0};
      end else if (mBusy && baudTick) begin
        mTicks++;
        if (mTicks == 160) begin mTxDone = 1; setNow = 1; end
        if (mTicks == 176) mBusy = 0;
      end
      if (hostWr && hostAddr == 2'd2) begin
        if (hostWrData[0] && !setNow) mTxDone = 0;
        if (hostWrData[1]) mRxFlag = 0;
      end
      if (hostWr && hostAddr == 2'd1) mCtrl = hostWrData[3:0];
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk("R1 R2 txLine", 16'(txLine), 16'(mBusy ? mFrame[mTicks/16] : 1'b1));
      chk("R3 txBusy", 16'(txBusy), 16'(mBusy));
      chk("R4 txDoneFlag", 16'(txDoneFlag), 16'(mTxDone));
      if (!rxWindow) begin
        chk("R10 rxFlag", 16'(rxFlag), 16'(mRxFlag));
        chk("R10 rxData", 16'(rxData), 16'(mRxData));
        chk("R10 rxNinth", 16'(rxNinth), 16'(mRxNinth));
        chk("R11 irq", 16'(irq), 16'(mCtrl[3] && (mTxDone || mRxFlag)));
      end
    end
  end

  task automatic hostWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    hostWr = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic sendBit(input logic b);
    rxLine = b;
    repeat (64) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic ninth, input logic stopLvl);
    rxWindow = 1'b1;
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(d[i]);
    sendBit(ninth);
    sendBit(stopLvl);
    rxLine = 1'b1;
    repeat (80) @(negedge clk);
    if (mCtrl[0] && !mRxFlag && (!mCtrl[1] || ninth)) begin
      mRxData = d; mRxNinth = ninth; mRxFlag = 1'b1;
    end
    rxWindow = 1'b0;
    @(negedge clk);
  endtask

  task automatic waitTxIdle();
    while (txBusy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R0 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 reset txLine", 16'(txLine), 16'd1);
    chk("R4 reset txDoneFlag", 16'(txDoneFlag), 16'd0);
    chk("R10 reset rxFlag", 16'(rxFlag), 16'd0);
    chk("R11 reset irq", 16'(irq), 16'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R2 ninth bit 1, R3 ignored write during busy
    hostWrite(2'd1, 8'b1101);
    hostWrite(2'd0, 8'hA5);
    repeat (40) @(negedge clk);
    hostWrite(2'd0, 8'h3C);
    chk("R3 busy after ignored write", 16'(txBusy), 16'd1);
    waitTxIdle();
    chk("R4 done held", 16'(txDoneFlag), 16'd1);
    hostWrite(2'd2, 8'h01);
    chk("R4 done cleared", 16'(txDoneFlag), 16'd0);

    // R2 ninth bit 0
    hostWrite(2'd1, 8'b1001);
    hostWrite(2'd0, 8'h5A);
    waitTxIdle();
    hostWrite(2'd2, 8'h01);

    // R10 accept, mode off, ninth 0 (R9 off case)
    sendFrame(8'h96, 1'b0, 1'b1);
    chk("R9 R10 accept ninth0 mp off", {7'd0, rxNinth, rxData}, 16'h0096);
    // R8 frame dropped while flag pending
    sendFrame(8'h11, 1'b1, 1'b1);
    chk("R8 pending drop", {7'd0, rxNinth, rxData}, 16'h0096);
    hostWrite(2'd2, 8'h02);
    chk("R10 flag cleared", 16'(rxFlag), 16'd0);

    // R9 address filter
    hostWrite(2'd1, 8'b1011);
    sendFrame(8'h42, 1'b0, 1'b1);
    chk("R9 filtered", {7'd0, rxFlag, rxData}, 16'h0096);
    sendFrame(8'h7E, 1'b1, 1'b1);
    chk("R9 address accepted", {6'd0, rxFlag, rxNinth, rxData}, 16'h037E);
    hostWrite(2'd2, 8'h02);

    // R7 low stop bit
    hostWrite(2'd1, 8'b1001);
    sendFrame(8'hC3, 1'b1, 1'b0);
    chk("R7 bad stop accepted", {6'd0, rxFlag, rxNinth, rxData}, 16'h03C3);
    hostWrite(2'd2, 8'h02);

    // R6 start glitch shorter than the vote point
    rxWindow = 1'b1;
    rxLine = 1'b0;
    repeat (16) @(negedge clk);
    rxLine = 1'b1;
    repeat (400) @(negedge clk);
    rxWindow = 1'b0;
    @(negedge clk);
    chk("R6 glitch ignored", {7'd0, rxFlag, rxData}, 16'h00C3);
    sendFrame(8'h5B, 1'b0, 1'b1);
    chk("R6 frame after glitch", 16'(rxData), 16'h005B);
    hostWrite(2'd2, 8'h02);

    // R5 receiver disabled
    hostWrite(2'd1, 8'b1000);
    sendFrame(8'hE7, 1'b1, 1'b1);
    chk("R5 disabled ignored", {7'd0, rxFlag, rxData}, 16'h005B);

    // R11 interrupt masked, then full duplex
    hostWrite(2'd1, 8'b0101);
    hostWrite(2'd0, 8'h81);
    sendFrame(8'h24, 1'b1, 1'b1);
    waitTxIdle();
    chk("R11 irq masked", 16'(irq), 16'd0);
    chk("R10 duplex rx", {6'd0, rxFlag, rxNinth, rxData}, 16'h0324);
    hostWrite(2'd1, 8'b1101);
    chk("R11 irq enabled", 16'(irq), 16'd1);
    hostWrite(2'd2, 8'h03);
    chk("R11 irq after clear", 16'(irq), 16'd0);

    repeat (10) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule